// File: doc/BRIEF.md
# E1 Slot-Zero Sync Monitor

This block sits on an E1 receive path whose bit stream is already aligned to a frame boundary. It runs on the recovered remote bit clock. A free-running bit counter, restarted by a frame-start strobe, locates slot zero in each 256-bit frame. The block reads the eight slot-zero bits, looks for the frame-alignment word that comes in every other frame, and keeps a locked or hunting state. From that state it drives a sync alarm, a channel-reset strobe and a slot-zero marker.

The block also drives a sync-word error level whose timing is exact, so a downstream counter can tally every errored alignment word. That includes the one-clock gaps it shows while hunting and the forced-low stretch after lock is regained. The spare bits of both slot-zero word types are presented as parallel outputs.

Bit numbering is 1 to 8 within a slot, with bit 1 arriving first. "Evaluation point" means bit 1 of slot 1, which is frame bit index 8 counted from 0.

Top module: `e1_ts0_monitor`

## Requirements
- R1: `ts0_pulse` is high exactly in the cycle that carries bit 1 of slot 0. That is the cycle in which `frame_start` is high, and every 256th cycle after it, even when `frame_start` is not repeated.
- R2: An alignment word has bits 2..8 equal to 0011011. While hunting, lock is declared only after three words in a row: an alignment word, then a word whose bit 2 is 1 in the next frame, then an alignment word in the frame after that. `sync_alarm` goes low in the cycle after the evaluation point of that third frame. A broken sequence leaves the alarm high.
- R3: While locked, the third alignment word in a row that contains an error makes `sync_alarm` go high in the cycle after that frame's evaluation point.
- R4: A correct alignment word clears the count of consecutive errored words, so two errors followed by a good word do not cause loss of lock.
- R5: `chan_rst_n` goes low for exactly one clock, at the evaluation point. While locked, this happens only in alignment-word frames. While hunting, it happens in every frame.
- R6: While locked, `sync_err` takes a new value at bit 2 of slot 1 (frame index 9) of each alignment-word frame. That value is high if the alignment word two frames earlier was in error, and low otherwise.
- R7: While hunting, `sync_err` is high. It drops for exactly one clock, at frame index 9, in any frame that comes two frames after a frame whose slot zero held a valid alignment word.
- R8: On regaining lock, `sync_err` is low from frame index 9 of the regaining frame until the next alignment-word frame reports at least. The first report then comes two frames later.
- R9: While locked, at the evaluation point of each non-alignment frame, both spare outputs update together. `spare_fas` becomes bit 1 of the previous frame's slot zero. `spare_nfas` becomes {bit 1, bits 3..8} of the current frame's slot zero, bit 1 in the MSB. While hunting, the spare outputs hold their values.
- R10: After reset the block is hunting: `sync_alarm`=1, `sync_err`=1, `chan_rst_n`=1, and both spare outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Remote bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | High during bit 1 of slot 0; restarts the bit counter |
| rx_data | input | 1 | Aligned serial E1 data |
| ts0_pulse | output | 1 | Marks bit 1 of slot 0 |
| chan_rst_n | output | 1 | Active-low channel reset strobe |
| sync_alarm | output | 1 | High while not locked |
| sync_err | output | 1 | Sync-word error level for error counting |
| spare_fas | output | 1 | Spare bit 1 of the alignment-word slot |
| spare_nfas | output | 7 | Bits 1 and 3..8 of the non-alignment slot |

## Verification
All state changes happen at the clock edge that ends the evaluation point (index 8). `sync_alarm`, `sync_err` levels and the spare outputs therefore show their new values from index 9. The one-clock error gap exists only at index 9. `ts0_pulse` and `chan_rst_n` follow the bit counter in the same cycle. The bench drives each bit on the falling edge and samples 2 ns later. For every frame it records the outputs at indices 8, 9 and 10, the position and number of channel-reset strobes, and any misplaced slot-zero marker. Each check compares one of these records against the value that the frame sequence calls for.

// File: rtl/e1_ts0_monitor.sv
module e1_ts0_monitor #(
  parameter int FRAME_BITS = 256,
  parameter int LOSS_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       rx_data,
  output logic       ts0_pulse,
  output logic       chan_rst_n,
  output logic       sync_alarm,
  output logic       sync_err,
  output logic       spare_fas,
  output logic [6:0] spare_nfas
);
  localparam int CW  = $clog2(FRAME_BITS);
  localparam int ECW = $clog2(LOSS_LIMIT + 1);
  localparam logic [6:0] ALIGN_PAT = 7'b0011011;

  typedef enum logic [1:0] {HUNT, GOT_F, GOT_N, LOCKED} st_t;

  st_t            st;
  logic [CW-1:0]  cnt, cur;
  logic [7:0]     sh;
  logic [2:0]     hist;
  logic [ECW-1:0] errcnt;
  logic           fas_frame, er_q, pend, a_hold;

  assign cur = frame_start ? '0 : cnt;

  wire eval    = (cur == CW'(8));
  wire gap_pos = (cur == CW'(9));
  wire fas_ok  = (sh[6:0] == ALIGN_PAT);
  wire in_sync = (st == LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= (cur == CW'(FRAME_BITS - 1)) ? '0 : cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              sh <= '0;
    else if (cur < CW'(8))   sh <= {sh[6:0], rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; fas_frame <= 1'b0; errcnt <= '0; er_q <= 1'b1;
      pend <= 1'b0; hist <= '0; a_hold <= 1'b0;
      spare_fas <= 1'b0; spare_nfas <= '0;
    end else if (eval) begin
      hist      <= {hist[1:0], fas_ok};
      a_hold    <= sh[7];
      fas_frame <= !fas_frame;
      if (!in_sync) er_q <= 1'b1;
      case (st)
        HUNT:  if (fas_ok) st <= GOT_F;
        GOT_F: st <= sh[6] ? GOT_N : HUNT;
        GOT_N:
          if (fas_ok) begin
            st <= LOCKED; fas_frame <= 1'b0; errcnt <= '0;
            er_q <= 1'b0; pend <= 1'b0;
          end else st <= HUNT;
        default:
          if (fas_frame) begin
            er_q <= pend;
            pend <= !fas_ok;
            if (fas_ok) errcnt <= '0;
            else if (errcnt == ECW'(LOSS_LIMIT - 1)) begin
              st <= HUNT; er_q <= 1'b1; errcnt <= '0;
            end else errcnt <= errcnt + 1'b1;
          end else begin
            spare_fas  <= a_hold;
            spare_nfas <= {sh[7], sh[5:0]};
          end
      endcase
    end
  end

  assign ts0_pulse  = (cur == '0);
  assign chan_rst_n = !(eval && (!in_sync || fas_frame));
  assign sync_alarm = !in_sync;
  assign sync_err   = er_q & !(gap_pos && !in_sync && hist[2]);

  assert_alarm_moves_at_eval_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_alarm) |-> $past(eval));
  assert_chan_rst_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_rst_n |=> chan_rst_n);
  assert_marker_apart_from_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ts0_pulse |-> chan_rst_n);
  assert_hunt_gap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !sync_err) |=> sync_err);
  assert_spares_move_at_eval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(spare_nfas) || !$stable(spare_fas)) |-> $past(eval));
endmodule

// File: tb/e1_ts0_monitor_test.sv
module e1_ts0_monitor_test;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, rx_data = 1'b0;
  logic ts0_pulse, chan_rst_n, sync_alarm, sync_err, spare_fas;
  logic [6:0] spare_nfas;

  e1_ts0_monitor uut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rx_data(rx_data), .ts0_pulse(ts0_pulse), .chan_rst_n(chan_rst_n),
    .sync_alarm(sync_alarm), .sync_err(sync_err), .spare_fas(spare_fas),
    .spare_nfas(spare_nfas));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, ts0_bad = 0, ccr_cnt = 0, ccr_pos = -1;
  logic er8, er9, er10, sa8, sa9;
  bit done = 0;

  localparam logic [7:0] E = 8'h00;
  function automatic logic [7:0] fw(input logic s); return {s, 7'b0011011}; endfunction
  function automatic logic [7:0] nw(input logic s, input logic [5:0] sp); return {s, 1'b1, sp}; endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int fi, input logic fs, input logic [7:0] s0);
    ccr_cnt = 0; ccr_pos = -1;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      frame_start = fs && (k == 0);
      rx_data = (k < 8) ? s0[7-k] : (((k * 5 + fi) % 3) == 0);
      #2;
      if (ts0_pulse !== (k == 0)) ts0_bad++;
      if (!chan_rst_n) begin ccr_cnt++; ccr_pos = k; end
      if (k == 8)  begin er8 = sync_err; sa8 = sync_alarm; end
      if (k == 9)  begin er9 = sync_err; sa9 = sync_alarm; end
      if (k == 10) er10 = sync_err;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R10 alarm", sync_alarm, 1); check("R10 err", sync_err, 1);
    check("R10 chan_rst", chan_rst_n, 1);
    check("R10 spares", {spare_fas, spare_nfas}, 0);

    send_frame(0, 1, fw(1));
    check("R5 hunt strobe count", ccr_cnt, 1); check("R5 hunt strobe pos", ccr_pos, 8);
    check("R2 alarm after first word", sa9, 1);
    send_frame(1, 0, nw(0, 6'h15));
    send_frame(2, 0, fw(0));
    check("R2 alarm at eval", sa8, 1); check("R2 lock", sa9, 0);
    check("R8 err at lock", er9, 0);
    send_frame(3, 0, nw(1, 6'h2A));
    check("R5 no strobe locked nfas", ccr_cnt, 0);
    check("R9 spare_fas", spare_fas, 0); check("R9 spare_nfas", spare_nfas, 7'h6A);
    send_frame(4, 0, fw(1));
    check("R5 locked fas strobe count", ccr_cnt, 1); check("R5 locked fas strobe pos", ccr_pos, 8);
    send_frame(5, 0, nw(0, 6'h03));
    send_frame(6, 0, E);
    send_frame(7, 0, nw(0, 6'h04));
    send_frame(8, 0, E);
    check("R6 err before report", er8, 0); check("R6 err reports", er9, 1);
    send_frame(9, 0, nw(0, 6'h05));
    send_frame(10, 1, fw(0));
    check("R4 still locked", sa9, 0); check("R6 second error report", er9, 1);
    send_frame(11, 0, nw(0, 6'h06));
    send_frame(12, 0, E);
    check("R6 err held", er8, 1); check("R6 clean report", er9, 0);
    check("R4 count cleared", sa9, 0);
    send_frame(13, 0, nw(0, 6'h07));
    send_frame(14, 0, E);
    check("R6 err rises", er9, 1); check("R3 still locked", sa9, 0);
    send_frame(15, 0, nw(1, 6'h0F));
    check("R9 spare_fas", spare_fas, 0); check("R9 spare_nfas", spare_nfas, 7'h4F);
    send_frame(16, 0, E);
    check("R3 alarm at eval", sa8, 0); check("R3 loss", sa9, 1);
    check("R5 last locked strobe", ccr_cnt, 1);
    send_frame(17, 0, nw(0, 6'h08));
    check("R5 hunt strobe", ccr_pos, 8); check("R7 err high", er9, 1);
    send_frame(18, 0, fw(1));
    send_frame(19, 0, E);
    send_frame(20, 0, nw(0, 6'h09));
    check("R7 before gap", er8, 1); check("R7 gap", er9, 0); check("R7 after gap", er10, 1);
    check("R2 broken sequence", sa9, 1);
    send_frame(21, 0, fw(0));
    send_frame(22, 0, nw(0, 6'h11));
    check("R9 hold fas", spare_fas, 0); check("R9 hold nfas", spare_nfas, 7'h4F);
    check("R7 no gap", er9, 1);
    send_frame(23, 0, fw(1));
    check("R2 relock", sa9, 0); check("R8 low at regain", er9, 0); check("R8 stays low", er10, 0);
    send_frame(24, 0, nw(0, 6'h33));
    check("R9 spare_fas", spare_fas, 1); check("R9 spare_nfas", spare_nfas, 7'h33);
    check("R8 low frame+1", er9, 0);
    send_frame(25, 0, E);
    check("R8 low frame+2", er9, 0);
    send_frame(26, 0, nw(0, 6'h01));
    send_frame(27, 0, fw(0));
    check("R6 report after regain", er9, 1);
    check("R1 marker placement", ts0_bad, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule